// File: doc/BRIEF.md
# Page-Bounded DMA Transfer Engine

This block moves a buffer between a peripheral and system memory without the processor touching the data. Software fills a short list of segments, each with a physical start address and a byte count. It then writes a control word that holds the transfer direction, the peripheral number and the index of the last list entry, and sets the go bit. The engine raises a bus request and steps through the list in order. It moves one 32-bit word in every cycle in which the bus grant is high. When the last segment is finished it raises a single interrupt.

No segment may leave its 4 KB physical page. A buffer that spans several pages is expressed as several list entries. When the go bit is written, every active entry is checked before anything moves. A count that is not a whole number of words, or a segment whose end runs past its page, ends the request at once. In that case the error and done flags are set, the interrupt is raised and no data moves.

Top module: `dma_page_engine`

## Requirements
- R1: After reset the status word (busy bit 0, done bit 1, error bit 2 at register offset 1) reads zero, and `irq` and `bus_req` are low.
- R2: With direction bit (CTRL bit 1) at 0, each moved word is popped from the peripheral (`dev_rd`) and written to memory. The words go to ascending word addresses starting at the segment address, in peripheral order.
- R3: With direction bit 1, each moved word is read from memory at ascending word addresses starting at the segment address and pushed to the peripheral (`dev_wr`), in address order.
- R4: `bus_req` is high for the whole transfer. A word moves only in a cycle where `bus_gnt` is high. While the grant is low nothing moves, and the transfer resumes afterwards without losing or repeating a word.
- R5: Segments 0 through the last index (CTRL bits 10:8) are processed in order. A zero-byte segment moves nothing and is skipped. Entries beyond the last index are neither used nor checked. Segment i has its address at register offset 2+2i and its byte count (bits 12:0) at offset 3+2i.
- R6: If an active segment's page offset plus byte count exceeds 4096, the go write sets error and done, raises `irq`, moves no word and never sets busy. A segment ending exactly at the page end is accepted.
- R7: A byte count that is not a multiple of 4 in any active segment is refused in the same way as R6.
- R8: `irq` stays low while the engine is busy. It rises when the last word of the last segment has moved, with status done set and busy clear.
- R9: Writing status with bit 1 set clears done, error and `irq`.
- R10: While busy, writes to the control word and to the segment list are ignored. The running transfer keeps its direction, addresses and counts, and the segment registers read back unchanged.
- R11: `dev_id` drives the peripheral number from CTRL bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq | output | 1 | Completion interrupt, follows done |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| dev_id | output | 4 | Selected peripheral number |
| dev_rd | output | 1 | Pop one word from the peripheral |
| dev_rdata | input | 32 | Peripheral word offered for popping |
| dev_wr | output | 1 | Push one word to the peripheral |
| dev_wdata | output | 32 | Word pushed to the peripheral |
| mem_addr | output | 32 | Memory byte address of the current word |
| mem_we | output | 1 | Memory write |
| mem_re | output | 1 | Memory read |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (combinational) |

## Verification
The hardest case to reach from the ports is a control or list write that lands while a transfer is under way. A write to an idle engine succeeds at once, and a normal transfer finishes within a few cycles. The bench therefore holds the bus grant low after a go write, so the engine waits in its busy state with its request raised. It then rewrites the segment address and the control word, reads the list back, and releases the grant. The bench checks that the data landed at the original addresses in the original direction. Random chains with a randomly toggling grant cover pauses that fall at segment joins and at zero-length segments.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int CNT_W     = PAGE_BITS + 1;
    localparam int WORD_W    = CNT_W - 2;
    localparam int DEV_W     = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } seg_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IDX_W = $clog2(NDESC),
    localparam int REG_AW = $clog2(2 + 2 * NDESC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [REG_AW-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    input  logic                    busy_i,
    input  logic                    finish_i,
    output logic                    start_o,
    output seg_t [NDESC-1:0]        seg_o,
    output logic [IDX_W-1:0]        last_o,
    output logic                    dir_o,
    output logic [DEV_W-1:0]        dev_o,
    output logic                    irq_o
);
    localparam logic [PAGE_BITS+1:0] PAGE_SZ = (PAGE_BITS + 2)'(1) << PAGE_BITS;

    typedef struct packed {
        seg_t [NDESC-1:0] seg;
        logic [IDX_W-1:0] last;
        logic             dir;
        logic [DEV_W-1:0] dev;
        logic             start;
        logic             done;
        logic             err;
    } regs_t;

    regs_t q, d;
    logic [NDESC-1:0] bad_vec, sel_vec;
    logic [IDX_W-1:0] new_last;
    logic             busy_all;

    assign new_last = wdata_i[8 +: IDX_W];
    assign busy_all = busy_i | q.start;

    for (genvar g = 0; g < NDESC; g++) begin : g_seg_chk
        logic [PAGE_BITS+1:0] end_off;
        assign end_off = {2'b00, q.seg[g].addr[PAGE_BITS-1:0]}
                       + {{(PAGE_BITS + 2 - CNT_W){1'b0}}, q.seg[g].cnt};
        assign bad_vec[g] = (q.seg[g].cnt[1:0] != 2'b00) || (end_off > PAGE_SZ);
        assign sel_vec[g] = (IDX_W'(g) <= new_last);
    end

    always_comb begin
        d = q;
        d.start = 1'b0;
        if (we_i) begin
            if (addr_i == REG_AW'(0)) begin
                if (!busy_all) begin
                    d.dir  = wdata_i[1];
                    d.dev  = wdata_i[7:4];
                    d.last = new_last;
                    if (wdata_i[0]) begin
                        if ((bad_vec & sel_vec) != '0) begin
                            d.err  = 1'b1;
                            d.done = 1'b1;
                        end else begin
                            d.err   = 1'b0;
                            d.done  = 1'b0;
                            d.start = 1'b1;
                        end
                    end
                end
            end else if (addr_i == REG_AW'(1)) begin
                if (wdata_i[1]) begin
                    d.done = 1'b0;
                    d.err  = 1'b0;
                end
            end else if (!busy_all) begin
                for (int i = 0; i < NDESC; i++) begin
                    if (addr_i == REG_AW'(2 + 2 * i)) d.seg[i].addr = wdata_i;
                    if (addr_i == REG_AW'(3 + 2 * i)) d.seg[i].cnt  = wdata_i[CNT_W-1:0];
                end
            end
        end
        if (finish_i) d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == REG_AW'(0)) begin
            rdata_o[1]           = q.dir;
            rdata_o[7:4]         = q.dev;
            rdata_o[8 +: IDX_W]  = q.last;
        end else if (addr_i == REG_AW'(1)) begin
            rdata_o[2:0] = {q.err, q.done, busy_all};
        end else begin
            for (int i = 0; i < NDESC; i++) begin
                if (addr_i == REG_AW'(2 + 2 * i)) rdata_o = q.seg[i].addr;
                if (addr_i == REG_AW'(3 + 2 * i)) rdata_o[CNT_W-1:0] = q.seg[i].cnt;
            end
        end
    end

    assign start_o = q.start;
    assign seg_o   = q.seg;
    assign last_o  = q.last;
    assign dir_o   = q.dir;
    assign dev_o   = q.dev;
    assign irq_o   = q.done;

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !busy_i);
    // R9
    clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == REG_AW'(1) && wdata_i[1] && !finish_i) |=> !irq_o);
    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> !$past(busy_i) && !busy_i);
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  seg_t [NDESC-1:0]     seg_i,
    input  logic [IDX_W-1:0]     last_i,
    input  logic                 dir_i,
    input  logic                 bus_gnt_i,
    input  logic [DATA_W-1:0]    dev_rdata_i,
    input  logic [DATA_W-1:0]    mem_rdata_i,
    output logic                 busy_o,
    output logic                 finish_o,
    output logic                 bus_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic                 mem_we_o,
    output logic                 mem_re_o,
    output logic [DATA_W-1:0]    mem_wdata_o,
    output logic                 dev_rd_o,
    output logic                 dev_wr_o,
    output logic [DATA_W-1:0]    dev_wdata_o
);
    typedef struct packed {
        logic              run;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [WORD_W-1:0] words;
    } xfer_t;

    xfer_t q, d;
    logic  move;
    logic [IDX_W-1:0] nidx;

    assign nidx = q.idx + IDX_W'(1);
    assign move = q.run && (q.words != '0) && bus_gnt_i;

    always_comb begin
        d = q;
        finish_o = 1'b0;
        if (!q.run) begin
            if (start_i) begin
                d.run   = 1'b1;
                d.idx   = '0;
                d.addr  = seg_i[0].addr;
                d.base  = seg_i[0].addr;
                d.words = seg_i[0].cnt[CNT_W-1:2];
            end
        end else if (q.words == '0) begin
            if (q.idx == last_i) begin
                d.run    = 1'b0;
                finish_o = 1'b1;
            end else begin
                d.idx   = nidx;
                d.addr  = seg_i[nidx].addr;
                d.base  = seg_i[nidx].addr;
                d.words = seg_i[nidx].cnt[CNT_W-1:2];
            end
        end else if (bus_gnt_i) begin
            d.addr  = q.addr + ADDR_W'(4);
            d.words = q.words - WORD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = q.run;
    assign bus_req_o   = q.run;
    assign mem_addr_o  = q.addr;
    assign mem_we_o    = move && !dir_i;
    assign dev_rd_o    = move && !dir_i;
    assign mem_re_o    = move && dir_i;
    assign dev_wr_o    = move && dir_i;
    assign mem_wdata_o = dev_rdata_i;
    assign dev_wdata_o = mem_rdata_i;

    // R4
    move_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> (bus_gnt_i && bus_req_o));
    // R6
    page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> (mem_addr_o[ADDR_W-1:PAGE_BITS] == q.base[ADDR_W-1:PAGE_BITS]));
    // R4
    hold_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !bus_gnt_i && q.words != '0) |=> $stable(mem_addr_o));
endmodule

// File: rtl/dma_page_engine.sv
module dma_page_engine
    import dma_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IDX_W = $clog2(NDESC),
    localparam int REG_AW = $clog2(2 + 2 * NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [3:0]        dev_id,
    output logic              dev_rd,
    input  logic [31:0]       dev_rdata,
    output logic              dev_wr,
    output logic [31:0]       dev_wdata,
    output logic [31:0]       mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    seg_t [NDESC-1:0] seg;
    logic [IDX_W-1:0] last;
    logic             dir, start, busy, finish;

    dma_regs #(.NDESC(NDESC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .addr_i   (cfg_addr),
        .wdata_i  (cfg_wdata),
        .rdata_o  (cfg_rdata),
        .busy_i   (busy),
        .finish_i (finish),
        .start_o  (start),
        .seg_o    (seg),
        .last_o   (last),
        .dir_o    (dir),
        .dev_o    (dev_id),
        .irq_o    (irq)
    );

    dma_xfer #(.NDESC(NDESC)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .seg_i       (seg),
        .last_i      (last),
        .dir_i       (dir),
        .bus_gnt_i   (bus_gnt),
        .dev_rdata_i (dev_rdata),
        .mem_rdata_i (mem_rdata),
        .busy_o      (busy),
        .finish_o    (finish),
        .bus_req_o   (bus_req),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .mem_wdata_o (mem_wdata),
        .dev_rd_o    (dev_rd),
        .dev_wr_o    (dev_wr),
        .dev_wdata_o (dev_wdata)
    );
endmodule

// File: tb/dma_page_engine_bench.sv
module dma_page_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, bus_req, dev_rd, dev_wr, mem_we, mem_re;
    logic        bus_gnt = 1'b0;
    logic [3:0]  dev_id;
    logic [31:0] dev_rdata, dev_wdata, mem_addr, mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    dma_page_engine u_dma_page_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .dev_id(dev_id),
        .dev_rd(dev_rd), .dev_rdata(dev_rdata), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // bench models
    logic [31:0] mem [0:8191];
    logic [31:0] sink [0:16383];
    logic [31:0] dev_seq = 32'h100;
    int          sink_n = 0;
    int          moves = 0;
    int          gnt_viol = 0;
    int          irq_busy = 0;
    logic [31:0] salt = 32'h1357_9bdf;
    int          gnt_mode = 1;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    function automatic logic [31:0] pat(input logic [31:0] a, input logic [31:0] s);
        return (a * 32'h9E37_79B1) ^ s;
    endfunction

    assign dev_rdata = dev_seq;
    assign mem_rdata = pat(mem_addr, salt);

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[14:2]] <= mem_wdata;
        if (dev_rd) dev_seq <= dev_seq + 1;
        if (dev_wr) begin
            sink[sink_n % 16384] <= dev_wdata;
            sink_n <= sink_n + 1;
        end
        if (mem_we || mem_re) moves <= moves + 1;
        if ((mem_we || mem_re) && !bus_gnt) gnt_viol <= gnt_viol + 1;
        if (irq && bus_req) irq_busy <= irq_busy + 1;
    end

    always @(negedge clk) begin
        if (gnt_mode == 0)      bus_gnt <= 1'b0;
        else if (gnt_mode == 1) bus_gnt <= 1'b1;
        else                    bus_gnt <= 1'($urandom % 2);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = 5'(a);
        #1 v = cfg_rdata;
    endtask

    task automatic wait_irq();
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    logic [31:0] jaddr [0:7];
    logic [12:0] jcnt  [0:7];

    task automatic load_list(input int n);
        for (int i = 0; i < n; i++) begin
            cfg_write(2 + 2 * i, jaddr[i]);
            cfg_write(3 + 2 * i, {19'd0, jcnt[i]});
        end
    endtask

    function automatic logic [31:0] ctrl_word(input bit dir, input logic [3:0] dev, input int last, input bit go);
        return {21'd0, 3'(last), dev, 2'b00, dir, go};
    endfunction

    // Runs a good job over list entries 0..n-1 and checks data (R2/R3/R5/R8)
    task automatic run_job(input bit dir, input logic [3:0] dev, input int n, input string req);
        logic [31:0] seq0, st;
        int          sn0, total, bad, k;
        logic [31:0] bad_act, bad_exp;
        load_list(n);
        seq0 = dev_seq; sn0 = sink_n; total = 0;
        for (int i = 0; i < n; i++) total += int'(jcnt[i]) / 4;
        cfg_write(0, ctrl_word(dir, dev, n - 1, 1'b1));
        // R11
        chk(dev_id == dev, "R11 dev_id", {28'd0, dev_id}, {28'd0, dev});
        wait_irq();
        cfg_read(1, st);
        // R8
        chk(irq && st[2:0] == 3'b010 && !bus_req, {req, " R8 completion"}, st, 32'h2);
        bad = 0; k = 0; bad_act = 0; bad_exp = 0;
        for (int i = 0; i < n; i++) begin
            for (int w = 0; w < int'(jcnt[i]) / 4; w++) begin
                logic [31:0] a, e, v;
                a = jaddr[i] + 32'(4 * w);
                if (!dir) begin
                    e = seq0 + 32'(k);
                    v = mem[a[14:2]];
                end else begin
                    e = pat(a, salt);
                    v = sink[(sn0 + k) % 16384];
                end
                if (v !== e && bad == 0) begin bad_act = v; bad_exp = e; end
                if (v !== e) bad++;
                k++;
            end
        end
        chk(bad == 0, {req, dir ? " R3 data" : " R2 data"}, bad_act, bad_exp);
        if (!dir) chk(dev_seq - seq0 == 32'(total), {req, " R2 word count"}, dev_seq - seq0, 32'(total));
        else      chk(sink_n - sn0 == total, {req, " R3 word count"}, 32'(sink_n - sn0), 32'(total));
    endtask

    task automatic rand_list(input int n);
        for (int i = 0; i < n; i++) begin
            int offw, words;
            words = int'($urandom % 33);
            offw  = int'($urandom % 1024);
            if (offw + words > 1024) offw = 1024 - words;
            jaddr[i] = 32'(i * 4096 + offw * 4);
            jcnt[i]  = 13'(words * 4);
        end
    endtask

    initial begin
        logic [31:0] v, st;
        int m0, s0;
        logic [31:0] q0;
        v = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_read(1, st);
        chk(st == 0 && !irq && !bus_req, "R1 reset state", st, 0);

        // R2 single segment, grant always high
        gnt_mode = 1;
        jaddr[0] = 32'h0000_0100; jcnt[0] = 13'd64;
        run_job(1'b0, 4'h5, 1, "directed");

        // R9 clear
        cfg_write(1, 32'h2);
        cfg_read(1, st);
        chk(st == 0 && !irq, "R9 clear done and irq", st, 0);

        // R3 R5 R4 chain with random grant and a zero segment
        gnt_mode = 2;
        jaddr[0] = 32'h0000_1FF0; jcnt[0] = 13'd16;
        jaddr[1] = 32'h0000_2000; jcnt[1] = 13'd0;
        jaddr[2] = 32'h0000_3000; jcnt[2] = 13'd4096;
        jaddr[3] = 32'h0000_4FFC; jcnt[3] = 13'd7;    // beyond last: R5 not checked
        load_list(4);
        run_job(1'b1, 4'hA, 3, "chain R5");
        cfg_write(1, 32'h2);

        // R6 boundary: ends exactly at page end, accepted
        gnt_mode = 1;
        jaddr[0] = 32'h0000_5FF8; jcnt[0] = 13'd8;
        run_job(1'b0, 4'h1, 1, "R6 exact page end");
        cfg_write(1, 32'h2);

        // R6 crossing refused
        m0 = moves;
        jaddr[0] = 32'h0000_0FF8; jcnt[0] = 13'd8;
        jaddr[1] = 32'h0000_6FFC; jcnt[1] = 13'd8;
        load_list(2);
        cfg_write(0, ctrl_word(1'b0, 4'h2, 1, 1'b1));
        repeat (5) @(negedge clk);
        cfg_read(1, st);
        chk(st == 32'h6 && irq && !bus_req, "R6 page cross refused", st, 32'h6);
        chk(moves == m0, "R6 no data moved", 32'(moves), 32'(m0));
        cfg_write(1, 32'h2);
        cfg_read(1, st);
        chk(st == 0 && !irq, "R9 clears error", st, 0);

        // R7 non-word count
        jaddr[0] = 32'h0000_0200; jcnt[0] = 13'd6;
        load_list(1);
        cfg_write(0, ctrl_word(1'b1, 4'h2, 0, 1'b1));
        repeat (3) @(negedge clk);
        cfg_read(1, st);
        chk(st == 32'h6 && irq && moves == m0, "R7 odd count refused", st, 32'h6);
        cfg_write(1, 32'h2);

        // R4 R10 stall under no grant, writes while busy
        gnt_mode = 0;
        jaddr[0] = 32'h0000_2000; jcnt[0] = 13'd16;
        load_list(1);
        q0 = dev_seq; s0 = sink_n; m0 = moves;
        cfg_write(0, ctrl_word(1'b0, 4'h3, 0, 1'b1));
        repeat (20) @(negedge clk);
        cfg_read(1, st);
        chk(bus_req && st[0] && moves == m0, "R4 request held, no move without grant", 32'(moves), 32'(m0));
        cfg_write(2, 32'h0000_3000);
        cfg_write(3, 32'd32);
        cfg_write(0, ctrl_word(1'b1, 4'h9, 0, 1'b1));
        cfg_read(2, v);
        chk(v == 32'h0000_2000, "R10 list write ignored while busy", v, 32'h2000);
        cfg_read(0, v);
        chk(v[1] == 1'b0 && v[7:4] == 4'h3, "R10 control write ignored while busy", v, 32'h30);
        gnt_mode = 2;
        wait_irq();
        chk(irq && !bus_req, "R8 finishes after stall", {31'd0, irq}, 1);
        chk(dev_seq - q0 == 4 && sink_n == s0, "R4 R10 word count and direction kept", dev_seq - q0, 4);
        chk(mem[12'h800] == q0 && mem[12'h803] == q0 + 3, "R2 R4 data after pauses", mem[12'h803], q0 + 3);
        cfg_write(1, 32'h2);

        // random jobs
        for (int j = 0; j < 14; j++) begin
            int n;
            n = 1 + int'($urandom % 8);
            gnt_mode = 1 + int'($urandom % 2);
            salt = $urandom;
            rand_list(n);
            run_job(1'($urandom % 2), 4'($urandom), n, "random R5");
            cfg_write(1, 32'h2);
        end

        // R4 R8 monitors
        chk(gnt_viol == 0, "R4 moves only with grant", 32'(gnt_viol), 0);
        chk(irq_busy == 0, "R8 irq never while busy", 32'(irq_busy), 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule